// File: doc/BRIEF.md
# Interrupt Remap Entry Validator

This block sits between the fetch of an interrupt remap table entry and the unit that logs remapping faults. For each request it receives the table index, the requester's source ID, the 128-bit entry that was read for that index, the current table size, and a flag saying whether the fetch failed. It runs a fixed sequence of validity checks and produces exactly one outcome: pass, or the first fault found. Alongside the outcome it produces a report flag, which tells the logging unit whether that fault must be recorded.

Reporting is gated in two ways. Each request carries a report-enable bit. Live interrupt writes set this bit. Speculative pre-translation lookups clear it, so that a lookup never raises a fault. The entry also carries a silence bit. This bit mutes reporting only for the checks that depend on the entry's contents, and the failing request still returns its fault reason.

Requests and results use a valid/ready handshake on each side. The result is held in a single output register and appears the cycle after the request is accepted.

Top module: `irq_remap_entry_check`

## Requirements
- R1: When the index is equal to or greater than the table size, the result is reason 1 (index overflow). This check outranks every other check.
- R2: When the index is in range and the fetch-error input is set, the result is reason 2 (fetch failure), whatever the entry holds.
- R3: A reason 1 or reason 2 result is reported whenever the request's report-enable is set, even if entry bit 1 (silence) is set.
- R4: When entry bit 1 (silence) is set, the result is not reported for any fault found after the fetch. The fault reason is still returned and the fault output stays high.
- R5: When entry bit 0 (present) is clear, the result is reason 3 (not present). This check comes after R1 and R2.
- R6: When any entry bit in [127:84] is nonzero, the result is reason 4 (reserved field). This check comes after the present check.
- R7: When the verify type (entry bits [83:82]) is 1, the block compares the requester ID with the entry source ID (bits [79:64]) under a mask chosen by the qualifier (bits [81:80]). The masks are 0:FFFF, 1:FFFB, 2:FFF9 and 3:FFF8. A mismatch gives reason 5 (source ID).
- R8: When the verify type is 2, the requester bus (ID bits [15:8]) must lie in the inclusive range from the entry's start bus (bits [79:72]) to its end bus (bits [71:64]). Otherwise the result is reason 5.
- R9: Verify type 3 always gives reason 5. Verify type 0 with no earlier fault gives reason 0 (pass), and the fault output is low.
- R10: When the request's report-enable is clear, the report output is never set.
- R11: The block accepts a request on a cycle where in_valid and in_ready are both high, and shows its result with out_valid on the next cycle. While out_ready is low, the result and out_valid hold and in_ready is low. If the result drains and a new request arrives in the same cycle, both complete.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_index | input | IDX_W | Remap table index |
| in_req_id | input | 16 | Requester source ID |
| in_entry | input | 128 | Fetched remap entry |
| in_fetch_err | input | 1 | Entry fetch failed |
| in_report_en | input | 1 | Request allows fault reporting |
| tbl_size | input | IDX_W+1 | Number of table entries |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_fault | output | 1 | Request failed |
| out_reason | output | 3 | Outcome code, 0 means pass |
| out_report | output | 1 | Fault must be logged |
| out_index | output | IDX_W | Index of the result's request |
| out_req_id | output | 16 | Requester ID of the result's request |

## Verification
Two things can happen in the same cycle. First, the held result can drain while a new request is accepted. The bench provokes this by stalling out_ready with a second request waiting and then releasing it. It judges the case by checking that the first result holds stable through the stall and that the second result follows directly. Second, several fault conditions can hold at once, for example an index overflow combined with a fetch error and a set silence bit. Directed and random requests stack these conditions, and each result is compared with a bench model that applies the check order and the reporting rules independently.

// File: rtl/irq_remap_pkg.sv
`timescale 1ns/1ps
package irq_remap_pkg;
  localparam int ENTRY_W     = 128;
  localparam int SID_W       = 16;
  localparam int BUS_W       = 8;
  localparam int PRESENT_BIT = 0;
  localparam int SILENCE_BIT = 1;
  localparam int SRC_LSB     = 64;
  localparam int QUAL_LSB    = SRC_LSB + SID_W;
  localparam int VTYPE_LSB   = QUAL_LSB + 2;
  localparam int RSVD_LSB    = VTYPE_LSB + 2;
  localparam int REASON_W    = 3;

  typedef enum logic [REASON_W-1:0] {
    RSN_PASS        = 3'd0,
    RSN_IDX_OVF     = 3'd1,
    RSN_FETCH       = 3'd2,
    RSN_NOT_PRESENT = 3'd3,
    RSN_RSVD        = 3'd4,
    RSN_SRC         = 3'd5
  } reason_e;

  typedef enum logic [1:0] {
    VT_NONE = 2'd0,
    VT_ID   = 2'd1,
    VT_BUS  = 2'd2,
    VT_BAD  = 2'd3
  } vtype_e;

  // Each qualifier step drops one more low bit from the compare, starting at bit 2.
  function automatic logic [SID_W-1:0] qual_mask(input logic [1:0] q);
    logic [SID_W-1:0] m;
    m = '1;
    for (int b = 0; b < 3; b++) begin
      if (int'(q) >= 3 - b) m[b] = 1'b0;
    end
    return m;
  endfunction

  function automatic logic id_match(input logic [SID_W-1:0] req,
                                    input logic [SID_W-1:0] src,
                                    input logic [1:0] q);
    return ((req ^ src) & qual_mask(q)) == '0;
  endfunction

  function automatic logic bus_in_range(input logic [BUS_W-1:0] bus,
                                        input logic [BUS_W-1:0] lo,
                                        input logic [BUS_W-1:0] hi);
    return (bus >= lo) && (bus <= hi);
  endfunction
endpackage

// File: rtl/irq_remap_src_verify.sv
`timescale 1ns/1ps
module irq_remap_src_verify
  import irq_remap_pkg::*;
(
  input  logic [SID_W-1:0] req_id,
  input  logic [SID_W-1:0] src_id,
  input  logic [1:0]       qual,
  input  logic [1:0]       vtype,
  output logic             src_bad
);
  logic id_ok;
  logic bus_ok;

  assign id_ok  = id_match(req_id, src_id, qual);
  assign bus_ok = bus_in_range(req_id[SID_W-1 -: BUS_W],
                               src_id[SID_W-1 -: BUS_W],
                               src_id[BUS_W-1:0]);

  always_comb begin
    unique case (vtype_e'(vtype))
      VT_NONE: src_bad = 1'b0;
      VT_ID:   src_bad = !id_ok;
      VT_BUS:  src_bad = !bus_ok;
      default: src_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/irq_remap_fault_prio.sv
`timescale 1ns/1ps
module irq_remap_fault_prio
  import irq_remap_pkg::*;
(
  input  logic    idx_ovf,
  input  logic    fetch_err,
  input  logic    not_present,
  input  logic    rsvd_bad,
  input  logic    src_bad,
  input  logic    silence,
  input  logic    report_en,
  output reason_e reason,
  output logic    early_fault,
  output logic    report
);
  always_comb begin
    reason      = RSN_PASS;
    early_fault = 1'b0;
    if (idx_ovf) begin
      reason      = RSN_IDX_OVF;
      early_fault = 1'b1;
    end else if (fetch_err) begin
      reason      = RSN_FETCH;
      early_fault = 1'b1;
    end else if (not_present) begin
      reason = RSN_NOT_PRESENT;
    end else if (rsvd_bad) begin
      reason = RSN_RSVD;
    end else if (src_bad) begin
      reason = RSN_SRC;
    end
  end

  // Entry-level silence only applies once the entry itself is trustworthy.
  assign report = (reason != RSN_PASS) && report_en && (early_fault || !silence);
endmodule

// File: rtl/irq_remap_result_reg.sv
`timescale 1ns/1ps
module irq_remap_result_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_remap_entry_check.sv
`timescale 1ns/1ps
module irq_remap_entry_check
  import irq_remap_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_index,
  input  logic [SID_W-1:0]   in_req_id,
  input  logic [ENTRY_W-1:0] in_entry,
  input  logic               in_fetch_err,
  input  logic               in_report_en,
  input  logic [IDX_W:0]     tbl_size,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_fault,
  output logic [REASON_W-1:0] out_reason,
  output logic               out_report,
  output logic [IDX_W-1:0]   out_index,
  output logic [SID_W-1:0]   out_req_id
);
  localparam int PAY_W = 1 + REASON_W + 1 + IDX_W + SID_W;

  // Named internal events, visible to the bound checker.
  logic    idx_ovf;
  logic    entry_silence;
  logic    not_present;
  logic    rsvd_bad;
  logic    src_bad;
  logic    early_fault;
  logic    report_d;
  logic    accept;
  reason_e reason_d;
  logic    unused_payload;

  logic [PAY_W-1:0] pay_d;
  logic [PAY_W-1:0] pay_q;

  assign idx_ovf        = {1'b0, in_index} >= tbl_size;
  assign entry_silence  = in_entry[SILENCE_BIT];
  assign not_present    = !in_entry[PRESENT_BIT];
  assign rsvd_bad       = |in_entry[ENTRY_W-1:RSVD_LSB];
  assign unused_payload = ^in_entry[SRC_LSB-1:SILENCE_BIT+1];

  irq_remap_src_verify u_src (
    .req_id  (in_req_id),
    .src_id  (in_entry[SRC_LSB +: SID_W]),
    .qual    (in_entry[QUAL_LSB +: 2]),
    .vtype   (in_entry[VTYPE_LSB +: 2]),
    .src_bad (src_bad)
  );

  irq_remap_fault_prio u_prio (
    .idx_ovf     (idx_ovf),
    .fetch_err   (in_fetch_err),
    .not_present (not_present),
    .rsvd_bad    (rsvd_bad),
    .src_bad     (src_bad),
    .silence     (entry_silence),
    .report_en   (in_report_en),
    .reason      (reason_d),
    .early_fault (early_fault),
    .report      (report_d)
  );

  assign pay_d  = {reason_d != RSN_PASS, reason_d, report_d, in_index, in_req_id};
  assign accept = in_valid && in_ready;

  irq_remap_result_reg #(.W(PAY_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (pay_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (pay_q)
  );

  assign {out_fault, out_reason, out_report, out_index, out_req_id} = pay_q;
endmodule

// File: rtl/irq_remap_checker.sv
`timescale 1ns/1ps
module irq_remap_checker #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_index,
  input logic             in_fetch_err,
  input logic             in_report_en,
  input logic             silence,
  input logic [IDX_W:0]   tbl_size,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_fault,
  input logic [2:0]       out_reason,
  input logic             out_report
);
  logic over;
  assign over = {1'b0, in_index} >= tbl_size;

  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && over |=> out_reason == 3'd1); // R1
  AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !over && in_fetch_err |=> out_reason == 3'd2); // R2
  AST_EARLY_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_report_en && (over || in_fetch_err) |=> out_report); // R3
  AST_SILENCED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && silence && !over && !in_fetch_err |=> !out_report); // R4
  AST_NO_REPORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_report_en |=> !out_report); // R10
  AST_REPORT_HAS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_report |-> out_fault); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reason) && $stable(out_report)); // R11
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11
endmodule

bind irq_remap_entry_check irq_remap_checker #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .in_ready     (in_ready),
  .in_index     (in_index),
  .in_fetch_err (in_fetch_err),
  .in_report_en (in_report_en),
  .silence      (entry_silence),
  .tbl_size     (tbl_size),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_fault    (out_fault),
  .out_reason   (out_reason),
  .out_report   (out_report)
);

// File: tb/irq_remap_entry_check_bench.sv
`timescale 1ns/1ps
module irq_remap_entry_check_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_index = '0;
  logic [15:0]  in_req_id = '0;
  logic [127:0] in_entry = '0;
  logic         in_fetch_err = 1'b0;
  logic         in_report_en = 1'b0;
  logic [16:0]  tbl_size = 17'd1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_fault;
  logic [2:0]   out_reason;
  logic         out_report;
  logic [15:0]  out_index;
  logic [15:0]  out_req_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_remap_entry_check u_irq_remap_entry_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_req_id(in_req_id), .in_entry(in_entry),
    .in_fetch_err(in_fetch_err), .in_report_en(in_report_en), .tbl_size(tbl_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
    .out_reason(out_reason), .out_report(out_report), .out_index(out_index),
    .out_req_id(out_req_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input bit p, input bit s, input logic [1:0] vt,
                                      input logic [1:0] q, input logic [15:0] src,
                                      input logic [43:0] rsvd);
    logic [127:0] e;
    e = {$urandom, $urandom, $urandom, $urandom};
    e[0] = p;
    e[1] = s;
    e[79:64] = src;
    e[81:80] = q;
    e[83:82] = vt;
    e[127:84] = rsvd;
    return e;
  endfunction

  function automatic int model_reason(input logic [15:0] idx, input logic [16:0] size,
                                      input bit ferr, input logic [127:0] e,
                                      input logic [15:0] req);
    logic [15:0] m;
    if ({1'b0, idx} >= size) return 1;
    if (ferr) return 2;
    if (e[0] == 1'b0) return 3;
    if (e[127:84] != '0) return 4;
    case (e[83:82])
      2'd0: return 0;
      2'd1: begin
        case (e[81:80])
          2'd0: m = 16'hFFFF;
          2'd1: m = 16'hFFFB;
          2'd2: m = 16'hFFF9;
          default: m = 16'hFFF8;
        endcase
        return ((req & m) == (e[79:64] & m)) ? 0 : 5;
      end
      2'd2: return (req[15:8] < e[79:72] || req[15:8] > e[71:64]) ? 5 : 0;
      default: return 5;
    endcase
  endfunction

  function automatic bit model_report(input int r, input bit en, input logic [127:0] e);
    if (r == 0 || !en) return 0;
    if (r <= 2) return 1;
    return !e[1];
  endfunction

  // Called at a falling edge; returns at the falling edge after the result appears.
  task automatic run_one(input string tag, input logic [15:0] idx, input logic [16:0] size,
                         input bit ferr, input logic [127:0] e, input logic [15:0] req,
                         input bit en);
    int r;
    r = model_reason(idx, size, ferr, e, req);
    in_index = idx; tbl_size = size; in_fetch_err = ferr; in_entry = e;
    in_req_id = req; in_report_en = en; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " reason"}, {29'd0, out_reason}, r);
    chk({tag, " report"}, {31'd0, out_report}, {31'd0, model_report(r, en, e)});
    chk({tag, " fault"}, {31'd0, out_fault}, {31'd0, r != 0});
    chk({tag, " index"}, {16'd0, out_index}, {16'd0, idx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 + R3: overflow beats fetch error, reported despite silence
    run_one("R1/R3 idx==size", 16'd64, 17'd64, 1, mk(0, 1, 2'd3, 2'd0, 16'h0, 44'h1), 16'h1, 1);
    run_one("R9 idx==size-1", 16'd63, 17'd64, 0, mk(1, 0, 2'd0, 2'd0, 16'h0, 44'h0), 16'h1, 1);
    run_one("R9 full table top", 16'hFFFF, 17'h10000, 0, mk(1, 0, 2'd0, 2'd0, 16'h0, 44'h0), 16'h1, 1);
    run_one("R2/R3 fetch+silence", 16'd5, 17'd64, 1, mk(1, 1, 2'd0, 2'd0, 16'h0, 44'h0), 16'h1, 1);
    run_one("R4/R5 notpresent silenced", 16'd5, 17'd64, 0, mk(0, 1, 2'd3, 2'd0, 16'h0, 44'h3), 16'h1, 1);
    run_one("R5 notpresent", 16'd5, 17'd64, 0, mk(0, 0, 2'd0, 2'd0, 16'h0, 44'h3), 16'h1, 1);
    run_one("R6 reserved", 16'd5, 17'd64, 0, mk(1, 0, 2'd3, 2'd0, 16'h0, 44'h800), 16'h1, 1);
    run_one("R4 reserved silenced", 16'd5, 17'd64, 0, mk(1, 1, 2'd0, 2'd0, 16'h0, 44'h1), 16'h1, 1);
    run_one("R7 q3 match", 16'd5, 17'd64, 0, mk(1, 0, 2'd1, 2'd3, 16'h1238, 44'h0), 16'h123F, 1);
    run_one("R7 q2 miss", 16'd5, 17'd64, 0, mk(1, 0, 2'd1, 2'd2, 16'h1238, 44'h0), 16'h123F, 1);
    run_one("R7 q1 match", 16'd5, 17'd64, 0, mk(1, 0, 2'd1, 2'd1, 16'h1230, 44'h0), 16'h1234, 1);
    run_one("R7 q0 miss", 16'd5, 17'd64, 0, mk(1, 0, 2'd1, 2'd0, 16'h1230, 44'h0), 16'h1234, 1);
    run_one("R8 bus low edge", 16'd5, 17'd64, 0, mk(1, 0, 2'd2, 2'd0, 16'h1020, 44'h0), 16'h10FF, 1);
    run_one("R8 bus high edge", 16'd5, 17'd64, 0, mk(1, 0, 2'd2, 2'd0, 16'h1020, 44'h0), 16'h2000, 1);
    run_one("R8 bus above", 16'd5, 17'd64, 0, mk(1, 0, 2'd2, 2'd0, 16'h1020, 44'h0), 16'h2100, 1);
    run_one("R8 bus below", 16'd5, 17'd64, 0, mk(1, 0, 2'd2, 2'd0, 16'h1020, 44'h0), 16'h0FFF, 1);
    run_one("R9 bad vtype", 16'd5, 17'd64, 0, mk(1, 0, 2'd3, 2'd0, 16'h0, 44'h0), 16'h0, 1);
    run_one("R10 overflow no report", 16'd70, 17'd64, 0, mk(1, 0, 2'd0, 2'd0, 16'h0, 44'h0), 16'h0, 0);
    run_one("R10 src no report", 16'd5, 17'd64, 0, mk(1, 0, 2'd3, 2'd0, 16'h0, 44'h0), 16'h0, 0);

    // R11: stall with a second request waiting, then drain and refill together
    @(negedge clk);
    in_index = 16'd9; tbl_size = 17'd64; in_fetch_err = 1'b0;
    in_entry = mk(0, 0, 2'd0, 2'd0, 16'h0, 44'h0); in_req_id = 16'h0; in_report_en = 1'b1;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11 first held valid", {31'd0, out_valid}, 32'd1);
    chk("R11 ready low when full", {31'd0, in_ready}, 32'd0);
    in_index = 16'd80;
    @(posedge clk); @(negedge clk);
    chk("R11 held reason", {29'd0, out_reason}, 32'd3);
    chk("R11 held index", {16'd0, out_index}, 32'd9);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R11 refill reason", {29'd0, out_reason}, 32'd1);
    chk("R11 refill index", {16'd0, out_index}, 32'd80);
    @(posedge clk); @(negedge clk);
    chk("R11 drained", {31'd0, out_valid}, 32'd0);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [16:0]  size;
      logic [15:0]  idx;
      logic [15:0]  req;
      logic [15:0]  src;
      logic [1:0]   vt;
      logic [127:0] e;
      int r;
      string tag;
      size = ($urandom % 4 == 0) ? 17'h10000 : 17'(1 + $urandom % 4096);
      idx  = ($urandom % 10 == 0) ? 16'(size + $urandom % 8) : 16'($urandom % size);
      req  = 16'($urandom);
      vt   = 2'($urandom);
      if (vt == 2'd1) src = ($urandom % 2) ? (req ^ 16'($urandom % 8)) : 16'($urandom);
      else begin
        src[15:8] = 8'(req[15:8] - $urandom % 3);
        src[7:0]  = 8'(req[15:8] + $urandom % 3 - 1);
      end
      e = mk($urandom % 6 != 0, $urandom % 3 == 0, vt, 2'($urandom), src,
             ($urandom % 7 == 0) ? 44'(1) << ($urandom % 44) : 44'h0);
      r = model_reason(idx, size, ($urandom % 10 == 0), e, req);
      case (r)
        1: tag = "R1 rand";
        2: tag = "R2 rand";
        3: tag = "R5 rand";
        4: tag = "R6 rand";
        5: tag = "R7 rand";
        default: tag = "R9 rand";
      endcase
      run_one(tag, idx, size, r == 2, e, req, $urandom % 4 != 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule